// File: doc/BRIEF.md
# Ultrasonic echo ranging controller

This block runs a trigger-and-echo ultrasonic range sensor and reports each echo as a fixed-point distance. It divides the system clock into a one-cycle microsecond tick. From that tick it raises `trig` for a fixed number of microseconds at the start of every measurement period. The sensor answers with a high level on `echo` whose width is the round-trip flight time of the sound burst.

The block brings `echo` into the clock domain through a two-stage synchroniser. It counts microsecond ticks while the synchronised echo is high and converts the count into a one-way distance in centimetres scaled by 1000: 17 units per microsecond. That is half of 340 m/s, with three fractional decimal digits.

A good result is announced with a one-cycle `distance_valid` strobe. Two failures load the all-ones code into `distance` and raise no strobe: an echo that lasts past the range limit, and a period that ends with no echo at all. Only one measurement is taken per trigger. Echo edges that arrive while `trig` is high are not acted on.

Top module: `sonar_ranger`

## Requirements
- R1: The microsecond tick occurs once every CLK_PER_US clock cycles, so a measurement period spans exactly PERIOD_US × CLK_PER_US clock cycles between consecutive rising edges of `trig`.
- R2: `trig` goes high on the first clock edge after reset is released. It then stays high for exactly TRIG_US × CLK_PER_US cycles at the start of every period and is low for the rest of the period.
- R3: While `rst` (synchronous, active high) is asserted, `trig` is driven low, `distance` is driven to 0 and `distance_valid` is driven low.
- R4: `echo` passes through two synchroniser flip-flops before edge detection. A falling edge of `echo` that ends a measurement produces `distance_valid` on the third clock edge after the change.
- R5: Each measurement counts the microsecond ticks seen from the detected rising edge of `echo` until its detected falling edge. On that falling edge `distance` is loaded with count × 17 and `distance_valid` is high for one cycle.
- R6: `distance_valid` is never high for two cycles in a row. `distance` holds its value between updates.
- R7: If the count reaches MAX_ECHO_US and one more tick arrives while `echo` is still high, the measurement is dropped. `distance` becomes all ones (0x7FFFF for 19 bits), no strobe is raised, and the later falling edge is ignored.
- R8: If a new period starts while the block is still waiting for a rising edge, or is still timing an echo, `distance` becomes all ones and no strobe is raised.
- R9: Rising or falling edges of the synchronised `echo` that are detected while `trig` is high have no effect.
- R10: After a result or a timeout, further echo pulses within the same period produce no strobe and leave `distance` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| echo | input | 1 | Asynchronous echo level from the sensor |
| trig | output | 1 | Trigger pulse to the sensor |
| distance | output | DIST_W (19) | Distance in cm × 1000, all ones on a dropped measurement |
| distance_valid | output | 1 | One-cycle strobe marking a new good distance |

## Verification
The main function is exercised with echo pulses of several widths and phases. A long pulse, an odd-length pulse and a pulse only a few cycles wide are each placed at a different offset from the tick, so that the tick-counting boundaries are distinguished from a plain cycle count. A period with no echo, and a pulse that outlasts the range limit, separate the two saturation paths from each other and from a good result. In one period, a pulse while `trig` is high is followed by a good pulse and then a late extra pulse. That period shows that trigger-time edges are masked and that only the first echo after a trigger is kept. A mid-run reset closes the sequence.

// File: rtl/sonar_pkg.sv
package sonar_pkg;

    // Measurement sequencing for one trigger period
    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,   // after reset, before the first trigger
        MS_ARMED  = 2'd1,   // trigger issued, waiting for echo to rise
        MS_TIMING = 2'd2,   // echo high, counting microseconds
        MS_DONE   = 2'd3    // result or timeout taken for this period
    } meas_state_e;

    // Events seen by the measurement sequencer in one clock
    typedef struct packed {
        logic start;   // a new trigger period has begun
        logic rise;    // synchronised echo went high (outside trigger)
        logic fall;    // synchronised echo went low (outside trigger)
    } echo_evt_t;

endpackage

// File: rtl/sonar_tick_gen.sv
module sonar_tick_gen #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/sonar_trig_sched.sv
module sonar_trig_sched #(
    parameter int PERIOD_US = 300000,
    parameter int TRIG_US   = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic trig
);
    localparam int PW = (PERIOD_US > 1) ? $clog2(PERIOD_US) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD_US - 1);
    localparam logic [PW-1:0] P_HIGH = PW'(TRIG_US);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == P_LAST) ? '0 : phase_q + PW'(1);
        end
    end

    // Registered so that reset holds the pin low
    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= 1'b0;
        end else begin
            trig <= (phase_q < P_HIGH);
        end
    end
endmodule

// File: rtl/sonar_echo_timer.sv
module sonar_echo_timer
    import sonar_pkg::*;
#(
    parameter int MAX_ECHO_US = 23530,
    parameter int SCALE       = 17,
    parameter int DIST_W      = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              trig,
    input  logic              echo,
    output logic [DIST_W-1:0] distance,
    output logic              distance_valid
);
    localparam int CNTW = $clog2(MAX_ECHO_US + 1);
    localparam logic [CNTW-1:0] CNT_LIMIT = CNTW'(MAX_ECHO_US);
    localparam logic [DIST_W-1:0] SAT = {DIST_W{1'b1}};

    logic [2:0]        sync_q;   // [0],[1] synchroniser, [2] previous level
    logic              trig_d;
    echo_evt_t         evt;
    meas_state_e       state_q;
    logic [CNTW-1:0]   us_q;
    logic [DIST_W-1:0] scaled;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            trig_d <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], echo};
            trig_d <= trig;
        end
    end

    always_comb begin
        evt.start = trig & ~trig_d;
        evt.rise  = sync_q[1] & ~sync_q[2] & ~trig;
        evt.fall  = ~sync_q[1] & sync_q[2] & ~trig;
    end

    assign scaled = DIST_W'(us_q) * DIST_W'(SCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= MS_IDLE;
            us_q           <= '0;
            distance       <= '0;
            distance_valid <= 1'b0;
        end else begin
            distance_valid <= 1'b0;
            if (evt.start) begin
                if (state_q == MS_ARMED || state_q == MS_TIMING) begin
                    distance <= SAT;
                end
                state_q <= MS_ARMED;
            end else begin
                unique case (state_q)
                    MS_ARMED: begin
                        if (evt.rise) begin
                            us_q    <= '0;
                            state_q <= MS_TIMING;
                        end
                    end
                    MS_TIMING: begin
                        if (evt.fall) begin
                            distance       <= scaled;
                            distance_valid <= 1'b1;
                            state_q        <= MS_DONE;
                        end else if (tick) begin
                            if (us_q >= CNT_LIMIT) begin
                                distance <= SAT;
                                state_q  <= MS_DONE;
                            end else begin
                                us_q <= us_q + CNTW'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sonar_ranger.sv
module sonar_ranger #(
    parameter int CLK_PER_US  = 50,
    parameter int TRIG_US     = 15,
    parameter int PERIOD_US   = 300000,
    parameter int MAX_ECHO_US = 23530,
    parameter int SCALE       = 17,
    parameter int DIST_W      = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              echo,
    output logic              trig,
    output logic [DIST_W-1:0] distance,
    output logic              distance_valid
);
    logic tick;

    sonar_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sonar_trig_sched #(.PERIOD_US(PERIOD_US), .TRIG_US(TRIG_US)) u_sched (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .trig (trig)
    );

    sonar_echo_timer #(
        .MAX_ECHO_US (MAX_ECHO_US),
        .SCALE       (SCALE),
        .DIST_W      (DIST_W)
    ) u_timer (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick),
        .trig           (trig),
        .echo           (echo),
        .distance       (distance),
        .distance_valid (distance_valid)
    );
endmodule

// File: rtl/sonar_ranger_chk.sv
module sonar_ranger_chk #(
    parameter int CLK_PER_US  = 50,
    parameter int TRIG_US     = 15,
    parameter int MAX_ECHO_US = 23530,
    parameter int SCALE       = 17,
    parameter int DIST_W      = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              trig,
    input logic [DIST_W-1:0] distance,
    input logic              distance_valid
);
    localparam int HI_LEN = TRIG_US * CLK_PER_US;
    localparam logic [DIST_W-1:0] SAT = {DIST_W{1'b1}};
    localparam logic [DIST_W-1:0] TOP_GOOD = DIST_W'(MAX_ECHO_US * SCALE);

    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) hi_cnt <= 0;
        else if (trig) hi_cnt <= hi_cnt + 1;
        else hi_cnt <= 0;
    end

    p_reset_clears_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!trig && distance == '0 && !distance_valid));

    p_trig_not_too_long_r2: assert property (@(posedge clk) disable iff (rst)
        trig |-> hi_cnt < HI_LEN);

    p_trig_full_width_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(trig) && !$past(rst)) |-> hi_cnt == HI_LEN);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        distance_valid |=> !distance_valid);

    p_valid_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        distance_valid |-> distance <= TOP_GOOD);

    p_no_result_from_trig_edges_r9: assert property (@(posedge clk) disable iff (rst)
        distance_valid |-> !$past(trig));

    p_silent_change_is_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(distance) && !distance_valid && !$past(rst)) |-> distance == SAT);
endmodule

bind sonar_ranger sonar_ranger_chk #(
    .CLK_PER_US  (CLK_PER_US),
    .TRIG_US     (TRIG_US),
    .MAX_ECHO_US (MAX_ECHO_US),
    .SCALE       (SCALE),
    .DIST_W      (DIST_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .trig           (trig),
    .distance       (distance),
    .distance_valid (distance_valid)
);

// File: tb/sonar_ranger_tb_top.sv
module sonar_ranger_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int P    = 300;
    localparam int T    = 15;
    localparam int MAXU = 100;
    localparam int SC   = 17;
    localparam int DW   = 19;
    localparam int SAT  = (1 << DW) - 1;
    localparam int WATCHDOG = 60000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic echo = 1'b0;
    logic trig;
    logic [DW-1:0] distance;
    logic dvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonar_ranger #(
        .CLK_PER_US(N), .TRIG_US(T), .PERIOD_US(P),
        .MAX_ECHO_US(MAXU), .SCALE(SC), .DIST_W(DW)
    ) dut_i (
        .clk(clk), .rst(rst), .echo(echo),
        .trig(trig), .distance(distance), .distance_valid(dvalid)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated once per rising edge
    int e = 0;
    bit live = 1'b0;
    bit m_trig, m_trigd, m_s1, m_s2, m_pv, m_valid;
    int m_st, m_cnt, m_dist;

    always @(posedge clk) begin
        bit tick_o, trig_o, trigd_o, s2_o, pv_o, rise, fall, start;
        live = 1'b1;
        if (rst) begin
            e = 0; m_trig = 0; m_trigd = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
            m_valid = 0; m_st = 0; m_cnt = 0; m_dist = 0;
        end else begin
            e = e + 1;
            tick_o  = (((e - 1) % N) == N - 1);            // R1 microsecond tick
            trig_o  = m_trig;
            trigd_o = m_trigd;
            s2_o    = m_s2;
            pv_o    = m_pv;
            m_trig  = ((((e - 1) / N) % P) < T);            // R2 trigger window
            m_trigd = trig_o;
            rise  = s2_o && !pv_o && !trig_o;               // R9 masking
            fall  = !s2_o && pv_o && !trig_o;
            start = trig_o && !trigd_o;
            m_pv = s2_o; m_s2 = m_s1; m_s1 = echo;           // R4 two-stage sync
            m_valid = 0;
            if (start) begin
                if (m_st == 1 || m_st == 2) m_dist = SAT;    // R8
                m_st = 1;
            end else if (m_st == 1) begin
                if (rise) begin m_st = 2; m_cnt = 0; end
            end else if (m_st == 2) begin
                if (fall) begin
                    m_dist = m_cnt * SC; m_valid = 1; m_st = 3;   // R5
                end else if (tick_o) begin
                    if (m_cnt >= MAXU) begin m_dist = SAT; m_st = 3; end  // R7
                    else m_cnt = m_cnt + 1;
                end
            end
        end
    end

    // Per-cycle comparison and monitors
    int cyc = 0;
    int valid_seen = 0;
    int last_dist = 0;
    int rise_cyc = -1;
    bit trig_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (live && !finished) begin
            check(trig === m_trig, "R2 trig", int'(trig), int'(m_trig));
            check(dvalid === m_valid, "R5 distance_valid", int'(dvalid), int'(m_valid));
            check(distance === DW'(m_dist), "R5 distance", int'(distance), m_dist);
            if (dvalid === 1'b1) begin
                valid_seen++;
                last_dist = int'(distance);
            end
            if (rst) begin
                rise_cyc = -1;
            end else if (trig && !trig_prev) begin
                if (rise_cyc >= 0)
                    check(cyc - rise_cyc == P * N, "R1 period", cyc - rise_cyc, P * N);
                rise_cyc = cyc;
            end else if (!trig && trig_prev && rise_cyc >= 0) begin
                check(cyc - rise_cyc == T * N, "R2 width", cyc - rise_cyc, T * N);
            end
            trig_prev = trig;
        end
    end

    task automatic wait_trig_fall();
        while (!trig) @(negedge clk);
        while (trig) @(negedge clk);
    endtask

    task automatic pulse(input int gap, input int len);
        repeat (gap) @(negedge clk);
        echo = 1'b1;
        repeat (len) @(negedge clk);
        echo = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int v0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(trig === 1'b0, "R3 trig in reset", int'(trig), 0);
        check(distance === '0, "R3 distance in reset", int'(distance), 0);
        check(dvalid === 1'b0, "R3 valid in reset", int'(dvalid), 0);
        rst = 1'b0;

        // Period 1: long pulse, 200 cycles = 50 us
        wait_trig_fall();
        v0 = valid_seen;
        pulse(20, 200);
        check(valid_seen == v0 + 1, "R5 one result p1", valid_seen - v0, 1);
        check(last_dist >= 49 * SC && last_dist <= 51 * SC, "R5 value p1", last_dist, 50 * SC);

        // Period 2: odd pulse, check synchroniser latency on the fall
        wait_trig_fall();
        repeat (13) @(negedge clk);
        echo = 1'b1;
        repeat (37) @(negedge clk);
        echo = 1'b0;
        @(negedge clk);
        check(dvalid === 1'b0, "R4 latency edge1", int'(dvalid), 0);
        @(negedge clk);
        check(dvalid === 1'b0, "R4 latency edge2", int'(dvalid), 0);
        @(negedge clk);
        check(dvalid === 1'b1, "R4 latency edge3", int'(dvalid), 1);

        // Period 3: very short pulse
        wait_trig_fall();
        v0 = valid_seen;
        pulse(5, 3);
        check(valid_seen == v0 + 1, "R5 short pulse result", valid_seen - v0, 1);
        check(last_dist <= SC, "R5 short pulse value", last_dist, SC);

        // Period 4: no echo; next trigger must saturate
        wait_trig_fall();
        v0 = valid_seen;
        while (!trig) @(negedge clk);
        repeat (3) @(negedge clk);
        check(distance === DW'(SAT), "R8 no echo saturates", int'(distance), SAT);
        check(valid_seen == v0, "R8 no strobe", valid_seen - v0, 0);

        // Period 5: normal pulse restores a good result
        wait_trig_fall();
        pulse(10, 60);
        check(distance !== DW'(SAT), "R5 recovery", int'(distance), last_dist);

        // Period 6: over-range echo
        wait_trig_fall();
        v0 = valid_seen;
        repeat (10) @(negedge clk);
        echo = 1'b1;
        repeat (500) @(negedge clk);
        check(distance === DW'(SAT), "R7 timeout saturates", int'(distance), SAT);
        echo = 1'b0;
        repeat (10) @(negedge clk);
        check(valid_seen == v0, "R7 late fall ignored", valid_seen - v0, 0);
        check(distance === DW'(SAT), "R7 value held", int'(distance), SAT);

        // Period 7: pulse under trig, then good pulse, then extra pulse
        while (!trig) @(negedge clk);
        v0 = valid_seen;
        repeat (10) @(negedge clk);
        echo = 1'b1;
        repeat (20) @(negedge clk);
        echo = 1'b0;
        repeat (20) @(negedge clk);
        check(valid_seen == v0, "R9 pulse during trig", valid_seen - v0, 0);
        wait_trig_fall();
        pulse(10, 80);
        check(valid_seen == v0 + 1, "R9 good pulse after trig", valid_seen - v0, 1);
        check(last_dist >= 19 * SC && last_dist <= 21 * SC, "R9 good value", last_dist, 20 * SC);
        v0 = valid_seen;
        begin
            int held;
            held = int'(distance);
            pulse(30, 40);
            check(valid_seen == v0, "R10 second pulse ignored", valid_seen - v0, 0);
            check(int'(distance) == held, "R10 distance held", int'(distance), held);
        end

        // Mid-run reset
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(trig === 1'b0, "R3 trig after reset", int'(trig), 0);
        check(distance === '0, "R3 distance after reset", int'(distance), 0);
        check(dvalid === 1'b0, "R3 valid after reset", int'(dvalid), 0);
        rst = 1'b0;
        repeat (100) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule